// File: doc/BRIEF.md
# Burst Address Sequencer

This block issues the address-phase sequence of one bus-master burst on a pipelined AHB-style bus. A start pulse presents a base address, a burst type, a transfer size and a beat count for undefined-length bursts. The block then drives HADDR, HTRANS, HBURST and HSIZE beat by beat. It advances only on cycles in which HREADY is high. It inserts BUSY cycles when the master side stalls, and it parks with IDLE when bus ownership is withdrawn. On regaining the bus it reissues the remaining beats as an undefined-length incrementing burst.

The start request is checked before any beat goes out. A misaligned base, an unsupported size, a zero-length undefined burst, or an incrementing burst that would run past a 1 KB page raises an error flag, and nothing is issued. The done flag is high whenever no burst is in flight, so a controller can chain bursts by waiting for it.

Top module: `burst_addr_seq`

## Requirements
- R1: After reset, and whenever no burst is active, `done_o` is 1, HTRANS is IDLE (2'b00) and `err_o` is 0 until a request is rejected.
- R2: The first beat of a burst is NONSEQ (2'b10) and each later beat is SEQ (2'b11). HBURST shows the requested type with the encoding 0 single, 1 undefined incrementing, 2/4/6 wrap 4/8/16, 3/5/7 incrementing 4/8/16. HSIZE shows the requested size.
- R3: In an incrementing burst each beat address is the previous one plus 2^size bytes, where size is 0, 1 or 2.
- R4: In a wrapping burst the address wraps inside an aligned window of (beats × 2^size) bytes.
- R5: A single burst issues exactly 1 beat, an undefined burst issues `len_i` beats, and fixed bursts issue 4, 8 or 16 beats.
- R6: While HREADY is low during an active burst, HADDR, HTRANS and HBURST do not change.
- R7: A high `stall_i` at the completion of a beat that has a successor makes the next cycle BUSY (2'b01), showing the next beat's address. SEQ follows on the first HREADY-high edge with `stall_i` low.
- R8: A low `grant_i` at a beat completion or a BUSY completion with beats left gives IDLE with `done_o` low until `grant_i` and HREADY are both high. The burst then resumes with a NONSEQ beat and HBURST = 1, following the original address sequence. In a resumed wrapping burst, a beat landing on the wrap window base is NONSEQ.
- R9: A start whose address is not aligned to 2^size, whose size exceeds 2, or whose undefined length is 0 issues no beat and sets `err_o` on the following cycle. `err_o` clears when the next start is accepted.
- R10: An incrementing start that would pass a 1 KB boundary is rejected as in R9. A burst ending exactly at the boundary is accepted.
- R11: A start pulse while a burst is active or parked is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Burst request pulse, taken only while idle |
| start_addr_i | input | 32 | Base address of the burst |
| burst_i | input | 3 | Burst type, encoded as in R2 |
| size_i | input | 3 | Transfer size, 2^size bytes |
| len_i | input | 8 | Beat count for undefined-length bursts |
| stall_i | input | 1 | Master not ready for the next beat |
| grant_i | input | 1 | Bus ownership held |
| hready_i | input | 1 | Bus ready, completes the current address phase |
| haddr_o | output | 32 | Beat address |
| htrans_o | output | 2 | Transfer type |
| hburst_o | output | 3 | Burst type on the bus |
| hsize_o | output | 3 | Transfer size on the bus |
| done_o | output | 1 | No burst in flight |
| err_o | output | 1 | Last start request rejected |

## Verification
A corrupted remaining-beat count shows up as a missing or extra beat on the bus at the end of the burst. A wrong stored wrap window appears on the first beat after the wrap point, so it surfaces within four beats for a 4-beat wrap. A wrong seam flag or lost rebuild state shows as the wrong HTRANS or HBURST code on the beat directly after a parked or BUSY cycle. The scoreboard compares address, type and burst code on every completed beat, so each of these faults is caught the cycle it reaches the ports.

// File: rtl/burst_seq_pkg.sv
package burst_seq_pkg;

    typedef enum logic [1:0] {
        TR_IDLE = 2'b00,
        TR_BUSY = 2'b01,
        TR_NSEQ = 2'b10,
        TR_SEQ  = 2'b11
    } trans_e;

    typedef enum logic [2:0] {
        BT_SINGLE = 3'd0,
        BT_INCR   = 3'd1,
        BT_WRAP4  = 3'd2,
        BT_INCR4  = 3'd3,
        BT_WRAP8  = 3'd4,
        BT_INCR8  = 3'd5,
        BT_WRAP16 = 3'd6,
        BT_INCR16 = 3'd7
    } burst_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_RUN,
        ST_PARK
    } state_e;

    // wrapping types are the even non-zero codes
    function automatic logic is_wrap(input logic [2:0] b);
        return (b[0] == 1'b0) && (b != 3'd0);
    endfunction

    // beat count of the fixed types; single and undefined handled by caller
    function automatic logic [4:0] fixed_beats(input logic [2:0] b);
        case (b[2:1])
            2'd1:    return 5'd4;
            2'd2:    return 5'd8;
            2'd3:    return 5'd16;
            default: return 5'd1;
        endcase
    endfunction

endpackage

// File: rtl/burst_req_check.sv
module burst_req_check
    import burst_seq_pkg::*;
#(
    parameter int AW       = 32,
    parameter int CNT_W    = 8,
    parameter int PAGE_W   = 10,
    parameter int MAX_SIZE = 2
) (
    input  logic [AW-1:0]     addr_i,
    input  logic [2:0]        burst_i,
    input  logic [2:0]        size_i,
    input  logic [CNT_W-1:0]  len_i,
    output logic              ok_o,
    output logic [CNT_W-1:0]  beats_o,
    output logic [PAGE_W-1:0] mask_o
);
    localparam int SPAN_W = CNT_W + 8;
    localparam int END_W  = SPAN_W + PAGE_W + 1;

    logic              size_ok;
    logic [2:0]        sz_eff;
    logic [AW-1:0]     amask;
    logic [SPAN_W-1:0] span;
    logic [END_W-1:0]  end_off;
    logic              aligned;
    logic              in_page;
    logic              wrap;

    always_comb begin
        size_ok = (size_i <= 3'(MAX_SIZE));
        sz_eff  = size_ok ? size_i : 3'd0;
        wrap    = is_wrap(burst_i);
        if (burst_i == BT_SINGLE)     beats_o = CNT_W'(1);
        else if (burst_i == BT_INCR)  beats_o = len_i;
        else                          beats_o = CNT_W'(fixed_beats(burst_i));
        amask   = (AW'(1) << sz_eff) - AW'(1);
        aligned = ((addr_i & amask) == '0);
        span    = SPAN_W'(beats_o) << sz_eff;
        end_off = END_W'(addr_i[PAGE_W-1:0]) + END_W'(span);
        in_page = (end_off <= (END_W'(1) << PAGE_W));
        mask_o  = wrap ? PAGE_W'(span - SPAN_W'(1)) : '0;
        ok_o    = size_ok && aligned && (beats_o != '0) && (wrap || in_page);
    end

endmodule

// File: rtl/burst_next_addr.sv
module burst_next_addr #(
    parameter int AW     = 32,
    parameter int PAGE_W = 10
) (
    input  logic [AW-1:0]     addr_i,
    input  logic [2:0]        size_i,
    input  logic              wrap_i,
    input  logic [PAGE_W-1:0] mask_i,
    output logic [AW-1:0]     next_o,
    output logic              wrapped_o
);
    logic [AW-1:0] sum;
    logic [AW-1:0] wmask;

    always_comb begin
        sum   = addr_i + (AW'(1) << size_i);
        wmask = AW'(mask_i);
        if (wrap_i) begin
            next_o    = (addr_i & ~wmask) | (sum & wmask);
            wrapped_o = ((sum & wmask) == '0);
        end else begin
            next_o    = sum;
            wrapped_o = 1'b0;
        end
    end

endmodule

// File: rtl/burst_addr_seq.sv
module burst_addr_seq
    import burst_seq_pkg::*;
#(
    parameter int AW       = 32,
    parameter int CNT_W    = 8,
    parameter int PAGE_W   = 10,
    parameter int MAX_SIZE = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start_i,
    input  logic [AW-1:0]    start_addr_i,
    input  logic [2:0]       burst_i,
    input  logic [2:0]       size_i,
    input  logic [CNT_W-1:0] len_i,
    input  logic             stall_i,
    input  logic             grant_i,
    input  logic             hready_i,
    output logic [AW-1:0]    haddr_o,
    output logic [1:0]       htrans_o,
    output logic [2:0]       hburst_o,
    output logic [2:0]       hsize_o,
    output logic             done_o,
    output logic             err_o
);
    typedef struct packed {
        state_e            st;
        logic [AW-1:0]     addr;
        trans_e            tr;
        burst_e            bu;
        logic [2:0]        sz;
        logic [CNT_W-1:0]  left;
        logic              wrap;
        logic [PAGE_W-1:0] mask;
        logic              rebuilt;
        logic              seg;
        logic              err;
    } seq_t;

    seq_t q, n;

    logic              req_ok;
    logic [CNT_W-1:0]  req_beats;
    logic [PAGE_W-1:0] req_mask;
    logic [AW-1:0]     nxt_addr;
    logic              nxt_wrapped;
    logic              beat_done;

    burst_req_check #(.AW(AW), .CNT_W(CNT_W), .PAGE_W(PAGE_W), .MAX_SIZE(MAX_SIZE)) u_chk (
        .addr_i  (start_addr_i),
        .burst_i (burst_i),
        .size_i  (size_i),
        .len_i   (len_i),
        .ok_o    (req_ok),
        .beats_o (req_beats),
        .mask_o  (req_mask)
    );

    burst_next_addr #(.AW(AW), .PAGE_W(PAGE_W)) u_nxt (
        .addr_i    (q.addr),
        .size_i    (q.sz),
        .wrap_i    (q.wrap),
        .mask_i    (q.mask),
        .next_o    (nxt_addr),
        .wrapped_o (nxt_wrapped)
    );

    assign beat_done = (q.tr == TR_NSEQ) || (q.tr == TR_SEQ);

    always_comb begin
        n = q;
        case (q.st)
            ST_IDLE: begin
                if (start_i) begin
                    if (req_ok) begin
                        n.st      = ST_RUN;
                        n.addr    = start_addr_i;
                        n.tr      = TR_NSEQ;
                        n.bu      = burst_e'(burst_i);
                        n.sz      = size_i;
                        n.left    = req_beats;
                        n.wrap    = is_wrap(burst_i);
                        n.mask    = req_mask;
                        n.rebuilt = 1'b0;
                        n.seg     = 1'b0;
                        n.err     = 1'b0;
                    end else begin
                        n.err = 1'b1;
                    end
                end
            end
            ST_RUN: begin
                if (hready_i) begin
                    if (beat_done && q.left == CNT_W'(1)) begin
                        n.st   = ST_IDLE;
                        n.tr   = TR_IDLE;
                        n.left = '0;
                    end else begin
                        if (beat_done) begin
                            n.addr = nxt_addr;
                            n.left = q.left - CNT_W'(1);
                            n.seg  = q.rebuilt & nxt_wrapped;
                        end
                        if (!grant_i) begin
                            n.st      = ST_PARK;
                            n.tr      = TR_IDLE;
                            n.bu      = BT_INCR;
                            n.rebuilt = 1'b1;
                        end else if (stall_i) begin
                            n.tr = TR_BUSY;
                        end else begin
                            n.tr = (beat_done ? (q.rebuilt & nxt_wrapped) : q.seg)
                                   ? TR_NSEQ : TR_SEQ;
                        end
                    end
                end
            end
            ST_PARK: begin
                if (grant_i && hready_i) begin
                    n.st = ST_RUN;
                    n.tr = TR_NSEQ;
                end
            end
            default: n.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            q <= '{st: ST_IDLE, addr: '0, tr: TR_IDLE, bu: BT_SINGLE, sz: '0,
                   left: '0, wrap: 1'b0, mask: '0, rebuilt: 1'b0, seg: 1'b0, err: 1'b0};
        end else begin
            q <= n;
        end
    end

    assign haddr_o  = q.addr;
    assign htrans_o = q.tr;
    assign hburst_o = q.bu;
    assign hsize_o  = q.sz;
    assign done_o   = (q.st == ST_IDLE);
    assign err_o    = q.err;

    // R6
    hold_stable_chk: assert property (@(posedge clk) disable iff (rst)
        (q.st == ST_RUN && !hready_i) |=>
        ($stable(haddr_o) && $stable(htrans_o) && $stable(hburst_o)));

    // R2
    seq_follows_chk: assert property (@(posedge clk) disable iff (rst)
        (htrans_o == TR_SEQ) |-> ($past(htrans_o) != TR_IDLE));

    // R1
    done_idle_chk: assert property (@(posedge clk) disable iff (rst)
        done_o |-> (htrans_o == TR_IDLE));

    // R9
    err_idle_chk: assert property (@(posedge clk) disable iff (rst)
        err_o |-> done_o);

    // R9
    beat_align_chk: assert property (@(posedge clk) disable iff (rst)
        (htrans_o != TR_IDLE) |-> ((haddr_o & ((AW'(1) << hsize_o) - AW'(1))) == '0));

    // R10
    same_page_chk: assert property (@(posedge clk) disable iff (rst)
        (htrans_o == TR_SEQ && $past(htrans_o) == TR_SEQ && $past(hready_i)) |->
        (haddr_o[AW-1:PAGE_W] == $past(haddr_o[AW-1:PAGE_W])));

endmodule

// File: tb/burst_addr_seq_tb.sv
module burst_addr_seq_tb;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start_i = 1'b0;
    logic [31:0] start_addr_i = '0;
    logic [2:0]  burst_i = '0;
    logic [2:0]  size_i = '0;
    logic [7:0]  len_i = '0;
    logic        stall_i = 1'b0;
    logic        grant_i = 1'b1;
    logic        hready_i = 1'b1;
    logic [31:0] haddr_o;
    logic [1:0]  htrans_o;
    logic [2:0]  hburst_o;
    logic [2:0]  hsize_o;
    logic        done_o;
    logic        err_o;

    typedef struct {
        logic [31:0] addr;
        logic [1:0]  tr;
        logic [2:0]  bu;
        string       tag;
    } exp_t;

    exp_t q[$];
    int n_chk = 0;
    int n_bad = 0;
    int stall_beat = -1;
    int lose_beat = -1;
    int beat_idx = 0;
    int busy_seen = 0;
    int park_seen = 0;
    bit hr_rand = 1'b0;
    logic [7:0] lfsr = 8'hA5;
    logic        prev_valid = 1'b0;
    logic        prev_hr = 1'b1;
    logic [31:0] prev_addr = '0;
    logic [1:0]  prev_tr = '0;

    burst_addr_seq u_dut (
        .clk(clk), .rst(rst), .start_i(start_i), .start_addr_i(start_addr_i),
        .burst_i(burst_i), .size_i(size_i), .len_i(len_i), .stall_i(stall_i),
        .grant_i(grant_i), .hready_i(hready_i), .haddr_o(haddr_o),
        .htrans_o(htrans_o), .hburst_o(hburst_o), .hsize_o(hsize_o),
        .done_o(done_o), .err_o(err_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input bit ok, input string tag, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s act=%0h exp=%0h", tag, what, act, exp);
        end
    endtask

    function automatic bit wrap_type(input logic [2:0] b);
        return (b[0] == 1'b0) && (b != 3'd0);
    endfunction

    task automatic push_burst(input logic [31:0] a, input logic [2:0] bu,
                              input logic [2:0] sz, input int len, input string tag);
        int beats;
        logic [31:0] bytes, span, base, ai;
        exp_t e;
        case (bu)
            3'd0: beats = 1;
            3'd1: beats = len;
            3'd2, 3'd3: beats = 4;
            3'd4, 3'd5: beats = 8;
            default: beats = 16;
        endcase
        bytes = 32'd1 << sz;
        span  = bytes * beats;
        base  = a & ~(span - 1);
        for (int i = 0; i < beats; i++) begin
            if (wrap_type(bu)) ai = base | ((a + i * bytes) & (span - 1));
            else               ai = a + i * bytes;
            e.addr = ai;
            e.tag  = tag;
            if (i == 0 || (lose_beat >= 1 && i == lose_beat))
                e.tr = 2'b10;
            else if (lose_beat >= 1 && i > lose_beat && wrap_type(bu) && (ai & (span - 1)) == 0)
                e.tr = 2'b10;
            else
                e.tr = 2'b11;
            e.bu = (lose_beat >= 1 && i >= lose_beat) ? 3'd1 : bu;
            q.push_back(e);
        end
    endtask

    task automatic run_burst(input logic [31:0] a, input logic [2:0] bu, input logic [2:0] sz,
                             input int len, input int stall, input int lose, input string tag);
        @(negedge clk);
        stall_beat = stall;
        lose_beat  = lose;
        beat_idx   = 0;
        push_burst(a, bu, sz, len, tag);
        start_i = 1'b1; start_addr_i = a; burst_i = bu; size_i = sz; len_i = 8'(len);
        @(negedge clk);
        start_i = 1'b0;
        check(hsize_o == sz, "R2", "hsize", 32'(hsize_o), 32'(sz));
        do @(negedge clk); while (!done_o);
        check(q.size() == 0, "R5", "beats missing", q.size(), 0);
        check(err_o == 1'b0, "R9", "err after accepted start", 32'(err_o), 0);
        q.delete();
        stall_beat = -1;
        lose_beat  = -1;
    endtask

    task automatic reject(input logic [31:0] a, input logic [2:0] bu, input logic [2:0] sz,
                          input int len, input string tag);
        @(negedge clk);
        start_i = 1'b1; start_addr_i = a; burst_i = bu; size_i = sz; len_i = 8'(len);
        @(negedge clk);
        start_i = 1'b0;
        check(err_o == 1'b1, tag, "err flag", 32'(err_o), 1);
        check(done_o == 1'b1, tag, "done on reject", 32'(done_o), 1);
        repeat (3) @(negedge clk);
        check(htrans_o == 2'b00, tag, "no beat on reject", 32'(htrans_o), 0);
    endtask

    // monitor: drives bus-side inputs and scores beats
    always @(negedge clk) begin
        if (!rst) begin
            lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
            hready_i = hr_rand ? (lfsr[0] | lfsr[2]) : 1'b1;
            stall_i  = 1'b0;
            grant_i  = 1'b1;
            if (prev_valid && !prev_hr && prev_tr != 2'b00)
                check(haddr_o == prev_addr && htrans_o == prev_tr, "R6", "hold during wait",
                      haddr_o, prev_addr);
            if (htrans_o == 2'b01) begin
                busy_seen++;
                if (q.size() != 0)
                    check(haddr_o == q[0].addr, "R7", "busy address", haddr_o, q[0].addr);
            end
            if (htrans_o == 2'b00 && !done_o) park_seen++;
            if (hready_i && htrans_o[1]) begin
                if (q.size() == 0) begin
                    check(1'b0, "R11", "unexpected beat", haddr_o, 0);
                end else begin
                    exp_t e;
                    e = q.pop_front();
                    check(haddr_o == e.addr, e.tag, "addr", haddr_o, e.addr);
                    check(htrans_o == e.tr, e.tag, "trans (R2)", 32'(htrans_o), 32'(e.tr));
                    check(hburst_o == e.bu, e.tag, "burst (R2)", 32'(hburst_o), 32'(e.bu));
                    if (beat_idx + 1 == stall_beat) stall_i = 1'b1;
                    if (beat_idx + 1 == lose_beat)  grant_i = 1'b0;
                    beat_idx++;
                end
            end
            prev_valid = 1'b1;
            prev_hr    = hready_i;
            prev_addr  = haddr_o;
            prev_tr    = htrans_o;
        end
    end

    task automatic finish_run();
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog expired act=0 exp=1");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        check(done_o == 1'b1, "R1", "done after reset", 32'(done_o), 1);
        check(htrans_o == 2'b00, "R1", "idle after reset", 32'(htrans_o), 0);
        check(err_o == 1'b0, "R1", "err after reset", 32'(err_o), 0);

        run_burst(32'h100, 3'd0, 3'd2, 0, -1, -1, "R5 single");
        run_burst(32'h200, 3'd3, 3'd2, 0, -1, -1, "R3 incr4");
        hr_rand = 1'b1;
        run_burst(32'h300, 3'd5, 3'd1, 0, -1, -1, "R3 R6 incr8 waits");
        run_burst(32'h038, 3'd2, 3'd2, 0, -1, -1, "R4 wrap4");
        run_burst(32'h106, 3'd4, 3'd1, 0, -1, -1, "R4 wrap8 half");
        run_burst(32'h4A4, 3'd6, 3'd0, 0, -1, -1, "R4 wrap16 byte");
        run_burst(32'h3F0, 3'd7, 3'd0, 0, -1, -1, "R10 incr16 to edge");
        run_burst(32'h020, 3'd1, 3'd1, 5, 2, -1, "R7 undef stall");
        check(busy_seen > 0, "R7", "busy cycles seen", busy_seen, 1);
        run_burst(32'h048, 3'd2, 3'd2, 0, -1, 1, "R8 wrap4 rebuilt");
        check(park_seen > 0, "R8", "park cycles seen", park_seen, 1);
        run_burst(32'h600, 3'd5, 3'd2, 0, 5, 3, "R8 incr8 rebuilt");
        hr_rand = 1'b0;

        reject(32'h102, 3'd3, 3'd2, 0, "R9 misaligned");
        reject(32'h100, 3'd0, 3'd3, 0, "R9 size too big");
        reject(32'h100, 3'd1, 3'd2, 0, "R9 zero length");
        reject(32'h3F8, 3'd3, 3'd2, 0, "R10 page cross");
        reject(32'h7FE, 3'd1, 3'd0, 3, "R10 undef cross");
        run_burst(32'h040, 3'd3, 3'd0, 0, -1, -1, "R9 clear");

        // R11 start during an active burst is ignored
        @(negedge clk);
        beat_idx = 0;
        push_burst(32'h000, 3'd7, 3'd2, 0, "R11 first burst");
        start_i = 1'b1; start_addr_i = 32'h000; burst_i = 3'd7; size_i = 3'd2;
        @(negedge clk);
        start_i = 1'b0;
        repeat (4) @(negedge clk);
        start_i = 1'b1; start_addr_i = 32'h800; burst_i = 3'd0; size_i = 3'd2;
        @(negedge clk);
        start_i = 1'b0;
        do @(negedge clk); while (!done_o);
        check(q.size() == 0, "R11", "first burst beats", q.size(), 0);
        repeat (4) @(negedge clk);
        check(htrans_o == 2'b00 && done_o, "R11", "no second burst", 32'(htrans_o), 0);

        finish_run();
    end

endmodule